// File: doc/BRIEF.md
# Receive Status Flag Clear Sequencer

This block keeps the status of a serial receiver: a flag that says a received byte is waiting, a flag that says a byte was lost, and the register holding the waiting byte. A receive shifter hands it finished bytes as a one-cycle strobe with data. Software sees the block through two one-cycle read strobes, one for the status and one for the data register.

Each flag is cleared by a two-step read sequence. A status read taken while the flag is set arms that flag's clear. The next data read carries out the clear. Each flag has its own arm bit, and that bit only records what the flag held at the moment of the status read.

Because of this, an overrun that lands between the status read and the data read is not cleared by that data read. The block can then show a lost-byte flag with no waiting byte, and the next status read followed by a data read clears it.

Top module: `rx_status_seq`

## Requirements
- R1: A synchronous active-high reset clears both flags, both arm bits and the data register to zero.
- R2: A byte strobe while the data-waiting flag is clear loads the byte into the data register and sets the data-waiting flag on the next cycle, with the lost-byte flag unchanged.
- R3: A byte strobe while the data-waiting flag is set, in a cycle with no clearing data read, sets the lost-byte flag and discards the byte. The data register keeps the earlier unread byte.
- R4: A status read while the data-waiting flag is 1 arms its clear. A later data read clears the flag. That data read consumes the arm bit.
- R5: A status read while the lost-byte flag is 1 arms its clear, and a later data read clears it.
- R6: If the lost-byte flag becomes set after the status read but before the data read, that data read clears the data-waiting flag and leaves the lost-byte flag at 1.
- R7: A status read, data read, status read, data read sequence leaves both flags at 0 when no byte arrives during it.
- R8: A status read while a flag is 0 does not arm it. A data read after the flag sets, with no fresh status read, leaves the flag set.
- R9: A data read with no armed flag leaves both flags and the data register unchanged.
- R10: A byte strobe in the same cycle as a data read that clears the data-waiting flag loads the new byte. The data-waiting flag stays 1 and no overrun is recorded.
- R11: When the status and data read strobes are both high in one cycle, only the data read takes effect, and both arm bits end at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_stb | input | 1 | One-cycle strobe: a received byte is complete |
| byte_data | input | DATA_W | Received byte, valid with byte_stb |
| rd_status | input | 1 | One-cycle strobe: status register is being read |
| rd_data | input | 1 | One-cycle strobe: data register is being read |
| full_o | output | 1 | Data-waiting flag |
| ovr_o | output | 1 | Lost-byte (overrun) flag |
| rx_data_o | output | DATA_W | Received data register |

## Verification
The hardest state to reach is a lost-byte flag set while the data-waiting flag is clear. It needs a byte, a status read, a second byte arriving before the data read, and only then the data read. A fixed-order directed test is not enough to cover every place that second byte could fall. The bench therefore runs every sequence of four cycles over byte strobe, status read and data read, starting from reset. Every arrival point relative to the two read steps is covered, including arrivals in the same cycle as a read.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    localparam int unsigned NUM_FLAGS = 2;
    localparam int unsigned IDX_FULL  = 0;
    localparam int unsigned IDX_OVR   = 1;

    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_STATUS = 2'd1,
        ACC_DATA   = 2'd2
    } acc_e;

    typedef struct packed {
        logic load;
        logic overrun;
    } byte_fate_t;

    // A data read wins over a coincident status read.
    function automatic acc_e decode_access(logic rs, logic rd);
        if (rd)      return ACC_DATA;
        else if (rs) return ACC_STATUS;
        else         return ACC_NONE;
    endfunction

    // A byte is lost only if the holding register stays occupied this cycle.
    function automatic byte_fate_t classify_byte(logic stb, logic full, logic full_clearing);
        byte_fate_t f;
        f.overrun = stb & full & ~full_clearing;
        f.load    = stb & ~f.overrun;
        return f;
    endfunction

endpackage

// File: rtl/rxs_flag_cell.sv
module rxs_flag_cell
    import rxs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  acc_e acc,
    input  logic set,
    output logic flag_o,
    output logic arm_o,
    output logic clr_o
);
    logic flag_q;
    logic arm_q;

    assign clr_o  = (acc == ACC_DATA) & arm_q;
    assign flag_o = flag_q;
    assign arm_o  = arm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            arm_q  <= 1'b0;
        end else begin
            flag_q <= set | (flag_q & ~clr_o);
            case (acc)
                ACC_STATUS: arm_q <= flag_q;
                ACC_DATA:   arm_q <= 1'b0;
                default:    arm_q <= arm_q;
            endcase
        end
    end
endmodule

// File: rtl/rxs_data_hold.sv
module rxs_data_hold #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst)       hold_q <= '0;
        else if (load) hold_q <= din;
    end

    assign dout = hold_q;
endmodule

// File: rtl/rx_status_seq.sv
module rx_status_seq
    import rxs_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              rd_status,
    input  logic              rd_data,
    output logic              full_o,
    output logic              ovr_o,
    output logic [DATA_W-1:0] rx_data_o
);
    acc_e                 acc;
    byte_fate_t           fate;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_q;
    logic [NUM_FLAGS-1:0] flag_arm;
    logic [NUM_FLAGS-1:0] flag_clr;

    assign acc  = decode_access(rd_status, rd_data);
    assign fate = classify_byte(byte_stb, flag_q[IDX_FULL], flag_clr[IDX_FULL]);

    always_comb begin
        flag_set           = '0;
        flag_set[IDX_FULL] = byte_stb;
        flag_set[IDX_OVR]  = fate.overrun;
    end

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        rxs_flag_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .acc    (acc),
            .set    (flag_set[g]),
            .flag_o (flag_q[g]),
            .arm_o  (flag_arm[g]),
            .clr_o  (flag_clr[g])
        );
    end

    rxs_data_hold #(.DATA_W(DATA_W)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .load (fate.load),
        .din  (byte_data),
        .dout (rx_data_o)
    );

    assign full_o = flag_q[IDX_FULL];
    assign ovr_o  = flag_q[IDX_OVR];
endmodule

// File: rtl/rxs_status_chk.sv
module rxs_status_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              byte_stb,
    input logic [DATA_W-1:0] byte_data,
    input logic              rd_status,
    input logic              rd_data,
    input logic              full_o,
    input logic              ovr_o,
    input logic [DATA_W-1:0] rx_data_o,
    input logic [1:0]        flag_arm
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!full_o && !ovr_o && rx_data_o == '0 && flag_arm == 2'b00));

    // R2
    byte_load_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_stb && !full_o) |=> (full_o && rx_data_o == $past(byte_data)));

    // R3
    overrun_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_o) |-> ($past(full_o) && $past(byte_stb) && $stable(rx_data_o)));

    // R4
    full_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(full_o) |-> ($past(rd_data) && $past(flag_arm[0])));

    // R5
    ovr_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ovr_o) |-> ($past(rd_data) && $past(flag_arm[1])));

    // R9
    unarmed_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data && flag_arm == 2'b00 && !byte_stb) |=>
            ($stable(full_o) && $stable(ovr_o) && $stable(rx_data_o)));

    // R11
    dual_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_status && rd_data) |=> (flag_arm == 2'b00));
endmodule

bind rx_status_seq rxs_status_chk #(.DATA_W(DATA_W)) u_status_chk (
    .clk       (clk),
    .rst       (rst),
    .byte_stb  (byte_stb),
    .byte_data (byte_data),
    .rd_status (rd_status),
    .rd_data   (rd_data),
    .full_o    (full_o),
    .ovr_o     (ovr_o),
    .rx_data_o (rx_data_o),
    .flag_arm  (flag_arm)
);

// File: tb/tb_rx_status_seq.sv
`timescale 1ns/100ps
module tb_rx_status_seq;
    localparam int unsigned DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          byte_stb = 1'b0;
    logic [DW-1:0] byte_data = '0;
    logic          rd_status = 1'b0;
    logic          rd_data = 1'b0;
    logic          full_o;
    logic          ovr_o;
    logic [DW-1:0] rx_data_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // expected-state model built from the requirements
    logic          m_full, m_ovr, m_arm_f, m_arm_o;
    logic [DW-1:0] m_data;
    string         m_tag;

    always #2.5 clk = ~clk;

    rx_status_seq #(.DATA_W(DW)) dut (
        .clk       (clk),
        .rst       (rst),
        .byte_stb  (byte_stb),
        .byte_data (byte_data),
        .rd_status (rd_status),
        .rd_data   (rd_data),
        .full_o    (full_o),
        .ovr_o     (ovr_o),
        .rx_data_o (rx_data_o)
    );

    task automatic chk(input string tag, input logic ef, input logic eo, input logic [DW-1:0] ed);
        checks++;
        if (full_o !== ef || ovr_o !== eo || rx_data_o !== ed) begin
            errors++;
            $display("FAIL %s: got full=%b ovr=%b data=%h, expected full=%b ovr=%b data=%h",
                     tag, full_o, ovr_o, rx_data_o, ef, eo, ed);
        end
    endtask

    task automatic reset_dut();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        m_full = 0; m_ovr = 0; m_arm_f = 0; m_arm_o = 0; m_data = '0;
    endtask

    task automatic step(input logic stb, input logic [DW-1:0] d, input logic rs, input logic rd);
        logic clr_f, clr_o, evt;
        @(negedge clk);
        byte_stb = stb; byte_data = d; rd_status = rs; rd_data = rd;
        @(posedge clk);
        #1;
        byte_stb = 1'b0; rd_status = 1'b0; rd_data = 1'b0;
        clr_f = rd && m_arm_f;
        clr_o = rd && m_arm_o;
        evt   = stb && m_full && !clr_f;
        if (evt)                  m_tag = "R3";
        else if (stb && clr_f)    m_tag = "R10";
        else if (stb)             m_tag = "R2";
        else if (rs && rd)        m_tag = "R11";
        else if (clr_f || clr_o)  m_tag = "R4";
        else if (rd)              m_tag = "R9";
        else                      m_tag = "R8";
        if (stb && !evt) m_data = d;
        m_ovr  = evt ? 1'b1 : (m_ovr && !clr_o);
        if (rs && !rd) begin
            m_arm_o = m_ovr_pre(m_ovr, evt, clr_o);
        end
        m_full = stb ? 1'b1 : (m_full && !clr_f);
    endtask

    // placeholder-free helper kept trivial: status arm uses pre-step values, handled in sweep_step
    function automatic logic m_ovr_pre(logic a, logic b, logic c);
        return a & ~b & ~c;
    endfunction

    // Sweep stepping with exact pre-edge arm capture
    task automatic sweep_step(input logic stb, input logic [DW-1:0] d, input logic rs, input logic rd);
        logic pf, po, paf, pao;
        pf = m_full; po = m_ovr; paf = m_arm_f; pao = m_arm_o;
        step(stb, d, rs, rd);
        if (rs && !rd) begin
            m_arm_f = pf;
            m_arm_o = po;
        end else if (rd) begin
            m_arm_f = 1'b0;
            m_arm_o = 1'b0;
        end else begin
            m_arm_f = paf;
            m_arm_o = pao;
        end
        chk({m_tag, " sweep"}, m_full, m_ovr, m_data);
    endtask

    initial begin
        #900000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        reset_dut();
        chk("R1 reset", 1'b0, 1'b0, 8'h00);

        sweep_step(1, 8'hA5, 0, 0);  chk("R2 load", 1, 0, 8'hA5);
        sweep_step(0, 8'h00, 0, 1);  chk("R9 unarmed read", 1, 0, 8'hA5);
        sweep_step(1, 8'h3C, 0, 0);  chk("R3 overrun keeps old byte", 1, 1, 8'hA5);
        sweep_step(0, 8'h00, 1, 0);
        sweep_step(0, 8'h00, 0, 1);  chk("R4 R5 two-step clear", 0, 0, 8'hA5);

        sweep_step(1, 8'h11, 0, 0);
        sweep_step(0, 8'h00, 1, 0);
        sweep_step(1, 8'h22, 0, 0);  chk("R3 late overrun", 1, 1, 8'h11);
        sweep_step(0, 8'h00, 0, 1);  chk("R6 overrun survives read", 0, 1, 8'h11);
        sweep_step(0, 8'h00, 1, 0);
        sweep_step(0, 8'h00, 0, 1);  chk("R7 second pair clears", 0, 0, 8'h11);

        sweep_step(0, 8'h00, 1, 0);
        sweep_step(1, 8'h33, 0, 0);
        sweep_step(0, 8'h00, 0, 1);  chk("R8 stale status read", 1, 0, 8'h33);
        sweep_step(0, 8'h00, 1, 0);
        sweep_step(0, 8'h00, 0, 1);  chk("R4 fresh pair clears", 0, 0, 8'h33);

        sweep_step(1, 8'h44, 0, 0);
        sweep_step(0, 8'h00, 1, 0);
        sweep_step(1, 8'h55, 0, 1);  chk("R10 byte with clearing read", 1, 0, 8'h55);
        sweep_step(0, 8'h00, 1, 1);  chk("R11 dual strobe", 1, 0, 8'h55);
        sweep_step(0, 8'h00, 0, 1);  chk("R11 dual strobe armed nothing", 1, 0, 8'h55);

        // every four-cycle pattern of (byte strobe, status read, data read) from reset
        for (int seq = 0; seq < 4096; seq++) begin
            reset_dut();
            for (int k = 0; k < 4; k++) begin
                logic [2:0] b;
                b = 3'((seq >> (3 * k)) & 7);
                sweep_step(b[0], 8'((seq * 4 + k + 1) & 8'hFF), b[1], b[2]);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule